// File: doc/BRIEF.md
# Processor Control Register File

This block holds the sixteen 16-bit control registers of a small processor core. A 4-bit index selects a register. Instructions that move a general register into a control register use the instruction write port. Instructions that move a control register out use the instruction read port. A second port lets a debugger read and write the same registers. The debugger port follows exactly the same masking and packing rules as the instruction port.

The status word is not kept as a stored 16-bit value. Its twelve defined bits live as separate flag flip-flops, and each flip-flop drives a flag output into the datapath. A write to the status word spreads the value over these flags. A read builds the word back from the flags. Some register bits can never be set.

Writing the status word with the saturation flag set and the fractional-mode flag clear is an illegal pairing. It raises a one-cycle illegal-instruction pulse. The ALU can update the two condition flags and the carry flag through a narrow port, without rewriting the whole word.

Top module: `ctl_regfile`

## Requirements
- R1: After a synchronous reset every register reads 0x0000, every flag output is 0, and `ill_op` is 0.
- R2: Index 0 is the status word, and each bit maps to one flag: bit 15 stack, bit 13 extended address, bit 12 debug, bit 11 debug mask, bit 10 interrupt enable, bit 9 repeat, bit 8 modulo, bit 7 fractional, bit 6 saturation, bit 3 condition 0, bit 2 condition 1, bit 0 carry. A write sets each flag output from its bit. A read of index 0 returns the word built from the flags.
- R3: On a write to index 0 (status) or index 1 (backup status), bits 14, 5, 4 and 1 are forced to zero, so the value read back is the written value AND 0xBFCD.
- R4: On a write to index 10 (modulo start) or index 11 (modulo end), bit 0 is forced to zero.
- R5: A write to index 0 with bit 6 set and bit 7 clear drives `ill_op` high for exactly the one cycle after the write edge. The flags still take the written value. No other write raises `ill_op`.
- R6: Every other index stores all 16 bits unchanged. This covers index 2 (program counter), 3 (backup program counter), 7, 8 and 9 (repeat count, start and end), 14 (instruction break address), and the unused indices 4, 5, 6, 12, 13 and 15.
- R7: A write shows on the read ports after the next rising clock edge. Reads are combinational. Without a write, a register keeps its value.
- R8: The debugger port applies the same masking, packing and illegal check as the instruction port. When both ports write in the same cycle, the debugger write wins and the instruction write is dropped.
- R9: When `alu_flag_we` is high, the condition 0, condition 1 and carry flags take the ALU values at the next edge, and the other flags stay unchanged. A status word write in the same cycle overrides the ALU update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_we | input | 1 | Instruction write enable |
| ins_wsel | input | 4 | Instruction write index |
| ins_wdata | input | 16 | Instruction write value |
| ins_rsel | input | 4 | Instruction read index |
| ins_rdata | output | 16 | Instruction read value (combinational) |
| dbg_we | input | 1 | Debugger write enable |
| dbg_sel | input | 4 | Debugger index, for both read and write |
| dbg_wdata | input | 16 | Debugger write value |
| dbg_rdata | output | 16 | Debugger read value (combinational) |
| alu_flag_we | input | 1 | ALU flag update enable |
| alu_cond0 | input | 1 | New condition 0 flag |
| alu_cond1 | input | 1 | New condition 1 flag |
| alu_carry | input | 1 | New carry flag |
| flg_stack | output | 1 | Stack flag (bit 15) |
| flg_xaddr | output | 1 | Extended address flag (bit 13) |
| flg_dbg | output | 1 | Debug flag (bit 12) |
| flg_dbgmask | output | 1 | Debug mask flag (bit 11) |
| flg_irqen | output | 1 | Interrupt enable flag (bit 10) |
| flg_rpt | output | 1 | Repeat flag (bit 9) |
| flg_modulo | output | 1 | Modulo flag (bit 8) |
| flg_frac | output | 1 | Fractional mode flag (bit 7) |
| flg_sat | output | 1 | Saturation flag (bit 6) |
| flg_cond0 | output | 1 | Condition 0 flag (bit 3) |
| flg_cond1 | output | 1 | Condition 1 flag (bit 2) |
| flg_carry | output | 1 | Carry flag (bit 0) |
| ill_op | output | 1 | Illegal-instruction pulse |

## Verification
A flag stored in the wrong position shows at once: the flag outputs and a status read disagree with the bench model one cycle after a single write. A missing or misplaced stuck-zero mask appears on the first all-ones write to the masked register. A wrong write priority or ALU merge shows on the read port right after the colliding edge. An illegal check that is wrong, or too broad, is visible as an `ill_op` level that differs from the bench model during the cycle after the write.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int CR_DW = 16;
  localparam int CR_AW = 4;

  // register indices that carry special rules
  localparam int IX_STAT  = 0;
  localparam int IX_BSTAT = 1;
  localparam int IX_MODS  = 10;
  localparam int IX_MODE  = 11;

  // status word bit positions
  localparam int B_STACK = 15;
  localparam int B_XADDR = 13;
  localparam int B_DBG   = 12;
  localparam int B_DMSK  = 11;
  localparam int B_IRQEN = 10;
  localparam int B_RPT   = 9;
  localparam int B_MOD   = 8;
  localparam int B_FRAC  = 7;
  localparam int B_SAT   = 6;
  localparam int B_CND0  = 3;
  localparam int B_CND1  = 2;
  localparam int B_CARRY = 0;

  localparam logic [CR_DW-1:0] STAT_KEEP = 16'hBFCD;
  localparam logic [CR_DW-1:0] MOD_KEEP  = 16'hFFFE;

  typedef struct packed {
    logic stack, xaddr, dbg, dmsk, irqen, rpt, modul, frac, sat, cnd0, cnd1, carry;
  } flags_t;
endpackage

// File: rtl/ctl_wr_arb.sv
module ctl_wr_arb
  import ctl_pkg::*;
#(
  parameter int DW = CR_DW,
  parameter int AW = CR_AW
) (
  input  logic          ins_we,
  input  logic [AW-1:0] ins_sel,
  input  logic [DW-1:0] ins_data,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_sel,
  input  logic [DW-1:0] dbg_data,
  output logic          w_en,
  output logic [AW-1:0] w_sel,
  output logic [DW-1:0] w_data,
  output logic          w_stat
);
  logic [DW-1:0] raw;
  logic [DW-1:0] keep;

  always_comb begin
    // the debugger has priority over the instruction stream
    if (dbg_we) begin
      w_sel = dbg_sel;
      raw   = dbg_data;
    end else begin
      w_sel = ins_sel;
      raw   = ins_data;
    end
    w_en = dbg_we | ins_we;
    if (w_sel == AW'(IX_STAT) || w_sel == AW'(IX_BSTAT))
      keep = STAT_KEEP;
    else if (w_sel == AW'(IX_MODS) || w_sel == AW'(IX_MODE))
      keep = MOD_KEEP;
    else
      keep = '1;
    w_data = raw & keep;
    w_stat = w_en && (w_sel == AW'(IX_STAT));
  end
endmodule

// File: rtl/ctl_status.sv
module ctl_status
  import ctl_pkg::*;
#(
  parameter int DW = CR_DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          alu_we,
  input  logic          alu_c0,
  input  logic          alu_c1,
  input  logic          alu_cy,
  output flags_t        flags,
  output logic [DW-1:0] word,
  output logic          illegal
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= wr && wdata[B_SAT] && !wdata[B_FRAC];
      if (wr) begin
        flags.stack <= wdata[B_STACK];
        flags.xaddr <= wdata[B_XADDR];
        flags.dbg   <= wdata[B_DBG];
        flags.dmsk  <= wdata[B_DMSK];
        flags.irqen <= wdata[B_IRQEN];
        flags.rpt   <= wdata[B_RPT];
        flags.modul <= wdata[B_MOD];
        flags.frac  <= wdata[B_FRAC];
        flags.sat   <= wdata[B_SAT];
        flags.cnd0  <= wdata[B_CND0];
        flags.cnd1  <= wdata[B_CND1];
        flags.carry <= wdata[B_CARRY];
      end else if (alu_we) begin
        flags.cnd0  <= alu_c0;
        flags.cnd1  <= alu_c1;
        flags.carry <= alu_cy;
      end
    end
  end

  always_comb begin
    word          = '0;
    word[B_STACK] = flags.stack;
    word[B_XADDR] = flags.xaddr;
    word[B_DBG]   = flags.dbg;
    word[B_DMSK]  = flags.dmsk;
    word[B_IRQEN] = flags.irqen;
    word[B_RPT]   = flags.rpt;
    word[B_MOD]   = flags.modul;
    word[B_FRAC]  = flags.frac;
    word[B_SAT]   = flags.sat;
    word[B_CND0]  = flags.cnd0;
    word[B_CND1]  = flags.cnd1;
    word[B_CARRY] = flags.carry;
  end
endmodule

// File: rtl/ctl_bank.sv
module ctl_bank
  import ctl_pkg::*;
#(
  parameter int DW = CR_DW,
  parameter int AW = CR_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wsel,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rsel_a,
  output logic [DW-1:0] rdata_a,
  input  logic [AW-1:0] rsel_b,
  output logic [DW-1:0] rdata_b
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst)
        mem[g] <= '0;
      else if (we && wsel == AW'(g))
        mem[g] <= wdata;
    end
  end

  assign rdata_a = mem[rsel_a];
  assign rdata_b = mem[rsel_b];
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile
  import ctl_pkg::*;
#(
  parameter int DW = CR_DW,
  parameter int AW = CR_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ins_we,
  input  logic [AW-1:0] ins_wsel,
  input  logic [DW-1:0] ins_wdata,
  input  logic [AW-1:0] ins_rsel,
  output logic [DW-1:0] ins_rdata,
  input  logic          dbg_we,
  input  logic [AW-1:0] dbg_sel,
  input  logic [DW-1:0] dbg_wdata,
  output logic [DW-1:0] dbg_rdata,
  input  logic          alu_flag_we,
  input  logic          alu_cond0,
  input  logic          alu_cond1,
  input  logic          alu_carry,
  output logic          flg_stack,
  output logic          flg_xaddr,
  output logic          flg_dbg,
  output logic          flg_dbgmask,
  output logic          flg_irqen,
  output logic          flg_rpt,
  output logic          flg_modulo,
  output logic          flg_frac,
  output logic          flg_sat,
  output logic          flg_cond0,
  output logic          flg_cond1,
  output logic          flg_carry,
  output logic          ill_op
);
  logic          w_en, w_stat;
  logic [AW-1:0] w_sel;
  logic [DW-1:0] w_data;
  logic [DW-1:0] stat_word, bank_a, bank_b;
  flags_t        flags;

  ctl_wr_arb #(.DW(DW), .AW(AW)) i_arb (
    .ins_we(ins_we), .ins_sel(ins_wsel), .ins_data(ins_wdata),
    .dbg_we(dbg_we), .dbg_sel(dbg_sel), .dbg_data(dbg_wdata),
    .w_en(w_en), .w_sel(w_sel), .w_data(w_data), .w_stat(w_stat)
  );

  ctl_status #(.DW(DW)) i_stat (
    .clk(clk), .rst(rst), .wr(w_stat), .wdata(w_data),
    .alu_we(alu_flag_we), .alu_c0(alu_cond0), .alu_c1(alu_cond1), .alu_cy(alu_carry),
    .flags(flags), .word(stat_word), .illegal(ill_op)
  );

  ctl_bank #(.DW(DW), .AW(AW)) i_bank (
    .clk(clk), .rst(rst), .we(w_en && !w_stat), .wsel(w_sel), .wdata(w_data),
    .rsel_a(ins_rsel), .rdata_a(bank_a), .rsel_b(dbg_sel), .rdata_b(bank_b)
  );

  assign ins_rdata = (ins_rsel == AW'(IX_STAT)) ? stat_word : bank_a;
  assign dbg_rdata = (dbg_sel  == AW'(IX_STAT)) ? stat_word : bank_b;

  assign flg_stack   = flags.stack;
  assign flg_xaddr   = flags.xaddr;
  assign flg_dbg     = flags.dbg;
  assign flg_dbgmask = flags.dmsk;
  assign flg_irqen   = flags.irqen;
  assign flg_rpt     = flags.rpt;
  assign flg_modulo  = flags.modul;
  assign flg_frac    = flags.frac;
  assign flg_sat     = flags.sat;
  assign flg_cond0   = flags.cnd0;
  assign flg_cond1   = flags.cnd1;
  assign flg_carry   = flags.carry;
endmodule

// File: rtl/ctl_regfile_chk.sv
module ctl_regfile_chk #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          ins_we,
  input logic [AW-1:0] ins_wsel,
  input logic [DW-1:0] ins_wdata,
  input logic [AW-1:0] ins_rsel,
  input logic [DW-1:0] ins_rdata,
  input logic          dbg_we,
  input logic [AW-1:0] dbg_sel,
  input logic [DW-1:0] dbg_wdata,
  input logic          alu_flag_we,
  input logic          alu_cond0,
  input logic          flg_stack,
  input logic          flg_frac,
  input logic          flg_sat,
  input logic          flg_cond0,
  input logic          flg_carry,
  input logic          ill_op
);
  logic any_we;
  logic stat_wr;
  assign any_we  = ins_we || dbg_we;
  assign stat_wr = dbg_we ? (dbg_sel == '0) : (ins_we && ins_wsel == '0);

  a_r3_stat_holes: assert property (@(posedge clk) disable iff (rst)
    (ins_rsel == AW'(0) || ins_rsel == AW'(1)) |-> (ins_rdata & 16'h4032) == '0);

  a_r4_mod_lsb: assert property (@(posedge clk) disable iff (rst)
    (ins_rsel == AW'(10) || ins_rsel == AW'(11)) |-> !ins_rdata[0]);

  a_r5_ill_raise: assert property (@(posedge clk) disable iff (rst)
    (dbg_we && dbg_sel == '0 && dbg_wdata[6] && !dbg_wdata[7]) |=> ill_op);

  a_r5_ill_quiet: assert property (@(posedge clk) disable iff (rst)
    !any_we |=> !ill_op);

  a_r7_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (!any_we && !alu_flag_we) |=> $stable({flg_stack, flg_frac, flg_sat, flg_cond0, flg_carry}));

  a_r9_alu_cond0: assert property (@(posedge clk) disable iff (rst)
    (alu_flag_we && !stat_wr) |=> flg_cond0 == $past(alu_cond0));
endmodule

bind ctl_regfile ctl_regfile_chk #(.DW(DW), .AW(AW)) i_chk (.*);

// File: tb/test_ctl_regfile.sv
`timescale 1ns/1ps
module test_ctl_regfile;
  logic        clk = 1'b0;
  logic        rst;
  logic        ins_we = 0, dbg_we = 0, alu_flag_we = 0;
  logic [3:0]  ins_wsel = 0, ins_rsel = 0, dbg_sel = 0;
  logic [15:0] ins_wdata = 0, dbg_wdata = 0;
  logic [15:0] ins_rdata, dbg_rdata;
  logic        alu_cond0 = 0, alu_cond1 = 0, alu_carry = 0;
  logic flg_stack, flg_xaddr, flg_dbg, flg_dbgmask, flg_irqen, flg_rpt;
  logic flg_modulo, flg_frac, flg_sat, flg_cond0, flg_cond1, flg_carry, ill_op;
  int total = 0, fails = 0;

  always #2.5 clk = ~clk;

  ctl_regfile i_ctl_regfile (.*);

  function automatic logic [15:0] flag_vec();
    return {flg_stack, 1'b0, flg_xaddr, flg_dbg, flg_dbgmask, flg_irqen, flg_rpt,
            flg_modulo, flg_frac, flg_sat, 2'b00, flg_cond0, flg_cond1, 1'b0, flg_carry};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic iwrite(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    ins_we = 1; ins_wsel = s; ins_wdata = d;
    @(negedge clk);
    ins_we = 0;
  endtask

  task automatic dwrite(input logic [3:0] s, input logic [15:0] d);
    @(negedge clk);
    dbg_we = 1; dbg_sel = s; dbg_wdata = d;
    @(negedge clk);
    dbg_we = 0;
  endtask

  task automatic iread(input logic [3:0] s, output logic [15:0] v);
    ins_rsel = s; #1; v = ins_rdata;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      iread(4'(i), v);
      check("R1 reset read", v, 16'h0);
    end
    check("R1 reset flags", flag_vec(), 16'h0);
    check("R1 reset ill", {15'b0, ill_op}, 16'h0);
  endtask

  task automatic t_status();
    logic [15:0] v;
    iwrite(4'd0, 16'hFFFF);
    iread(4'd0, v);
    check("R3 status all ones", v, 16'hBFCD);
    check("R2 flags all ones", flag_vec(), 16'hBFCD);
    iwrite(4'd0, 16'hA5C9);
    iread(4'd0, v);
    check("R2 status pattern", v, 16'hA5C9 & 16'hBFCD);
    check("R2 flags pattern", flag_vec(), 16'hA5C9 & 16'hBFCD);
    iwrite(4'd0, 16'h5A36);
    check("R2 flags pattern2", flag_vec(), 16'h5A36 & 16'hBFCD);
    iwrite(4'd1, 16'hFFFF);
    iread(4'd1, v);
    check("R3 backup mask", v, 16'hBFCD);
    check("R3 backup leaves flags", flag_vec(), 16'h5A36 & 16'hBFCD);
  endtask

  task automatic t_other();
    logic [15:0] v;
    iwrite(4'd10, 16'hFFFF);
    iwrite(4'd11, 16'h1235);
    iread(4'd10, v); check("R4 modulo start", v, 16'hFFFE);
    iread(4'd11, v); check("R4 modulo end", v, 16'h1234);
    for (int i = 2; i < 16; i++)
      if (i != 10 && i != 11) iwrite(4'(i), 16'hC301 ^ 16'(i * 16'h0111));
    for (int i = 2; i < 16; i++)
      if (i != 10 && i != 11) begin
        iread(4'(i), v);
        check("R6 full store", v, 16'hC301 ^ 16'(i * 16'h0111));
      end
  endtask

  task automatic t_timing();
    logic [15:0] v;
    @(negedge clk);
    ins_we = 1; ins_wsel = 4'd3; ins_wdata = 16'h7E57;
    iread(4'd3, v);
    check("R7 not yet visible", v, 16'hC301 ^ 16'(3 * 16'h0111));
    @(negedge clk); ins_we = 0;
    iread(4'd3, v);
    check("R7 visible after edge", v, 16'h7E57);
    repeat (3) @(negedge clk);
    iread(4'd3, v);
    check("R7 holds", v, 16'h7E57);
  endtask

  task automatic t_illegal();
    iwrite(4'd0, 16'h0040);
    check("R5 ill pulse", {15'b0, ill_op}, 16'h1);
    check("R5 flags still written", flag_vec(), 16'h0040);
    @(negedge clk);
    check("R5 ill one cycle", {15'b0, ill_op}, 16'h0);
    iwrite(4'd0, 16'h00C0);
    check("R5 legal pairing", {15'b0, ill_op}, 16'h0);
    iwrite(4'd1, 16'h0040);
    check("R5 backup no ill", {15'b0, ill_op}, 16'h0);
    dwrite(4'd0, 16'h0040);
    check("R8 dbg ill pulse", {15'b0, ill_op}, 16'h1);
  endtask

  task automatic t_debug();
    logic [15:0] v;
    dwrite(4'd0, 16'hFFFF);
    dbg_sel = 4'd0; #1;
    check("R8 dbg status read", dbg_rdata, 16'hBFCD);
    dwrite(4'd11, 16'h00FF);
    dbg_sel = 4'd11; #1;
    check("R8 dbg modulo mask", dbg_rdata, 16'h00FE);
    @(negedge clk);
    ins_we = 1; ins_wsel = 4'd8; ins_wdata = 16'h1111;
    dbg_we = 1; dbg_sel = 4'd8; dbg_wdata = 16'h2222;
    @(negedge clk);
    ins_we = 0; dbg_we = 0;
    iread(4'd8, v);
    check("R8 dbg wins", v, 16'h2222);
  endtask

  task automatic t_alu();
    logic [15:0] v;
    iwrite(4'd0, 16'h8080);
    @(negedge clk);
    alu_flag_we = 1; alu_cond0 = 1; alu_cond1 = 1; alu_carry = 1;
    @(negedge clk);
    alu_flag_we = 0;
    iread(4'd0, v);
    check("R9 alu update", v, 16'h808D);
    @(negedge clk);
    alu_flag_we = 1; alu_cond0 = 0; alu_cond1 = 1; alu_carry = 0;
    ins_we = 1; ins_wsel = 4'd0; ins_wdata = 16'h0009;
    @(negedge clk);
    alu_flag_we = 0; ins_we = 0;
    iread(4'd0, v);
    check("R9 word write overrides", v, 16'h0009);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_status();
    t_other();
    t_timing();
    t_illegal();
    t_debug();
    t_alu();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule